// File: doc/BRIEF.md
# Instruction Control Decoder

This block is the control unit of a single-cycle 32-bit load-store processor. It looks at two fields of the instruction that has just been fetched: the 6-bit major opcode in bits 31:26 and the 6-bit function field in bits 5:0. From them it produces, in the same cycle and with no state, every select and enable that steers the datapath. These are the register-file write enable, the choice of destination register field, the ALU second-operand source, the writeback source, the data-memory read and write strobes, the branch and jump flags, the immediate extension mode and a 4-bit ALU operation code.

The supported set has four parts. The register-register operations are signed and unsigned add and subtract, the four bitwise operations and the two set-less-than forms. The immediate forms cover arithmetic, compare and bitwise logic. The memory operations are word load and word store. Control flow is branch-if-equal and an absolute jump. Any other encoding raises an illegal flag, and while that flag is set every control output is held at zero, so an undefined instruction can change no state.

Top module: `instr_ctrl_decoder`

## Requirements
- R1: With opcode 000000 and funct 32,33,34,35,36,37,38,39,42,43 (add, addu, sub, subu, and, or, xor, nor, slt, sltu), the outputs are reg_wr=1, dst_rd=1, alu_src_imm=0 and all memory, branch and jump outputs 0. alu_op is then ADD=0010, ADDU=0011, SUB=0110, SUBU=0101, AND=0000, OR=0001, XOR=0100, NOR=1100, SLT=0111 or SLTU=1000.
- R2: Opcodes 001000, 001001, 001010, 001011, 001100, 001101, 001110 give reg_wr=1, dst_rd=0 and alu_src_imm=1, with no memory or flow outputs set. alu_op is ADD, ADDU, SLT, SLTU, AND, OR, XOR respectively.
- R3: ext_sign=1 (sign extension) for opcodes 001000, 001001, 001010, 001011, 100011, 101011 and 000100. ext_sign=0 (zero extension) for 001100, 001101 and 001110, and for all other encodings.
- R4: Load (opcode 100011) gives reg_wr=1, dst_rd=0, alu_src_imm=1, mem_to_reg=1, mem_rd=1, mem_wr=0 and alu_op=ADD.
- R5: Store (opcode 101011) gives mem_wr=1, alu_src_imm=1, alu_op=ADD and reg_wr=0, with no read and no writeback.
- R6: Branch-if-equal (opcode 000100) gives branch=1, alu_op=SUB, alu_src_imm=0 and reg_wr=0.
- R7: Jump (opcode 000010) gives jump=1, and every other control output is 0, with alu_op=0000.
- R8: An opcode not named in R1 to R7, or opcode 000000 with a funct not named in R1, gives illegal=1 and drives every other output to 0.
- R9: For a non-zero opcode the funct input has no effect on any output.
- R10: At most one of branch, jump, mem_rd and mem_wr is set at any time, and mem_to_reg is never set without mem_rd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Major opcode, instruction bits 31:26 |
| funct | input | 6 | Function field, instruction bits 5:0 |
| reg_wr | output | 1 | Register file write enable |
| dst_rd | output | 1 | 1 selects the rd field as destination, 0 selects rt |
| alu_src_imm | output | 1 | 1 feeds the extended immediate to ALU operand B |
| mem_to_reg | output | 1 | 1 writes memory read data back instead of the ALU result |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| branch | output | 1 | Branch-if-equal in progress; qualify with ALU zero |
| jump | output | 1 | Absolute jump in progress |
| ext_sign | output | 1 | 1 sign-extends the 16-bit immediate, 0 zero-extends it |
| alu_op | output | 4 | ALU operation code |
| illegal | output | 1 | Unsupported encoding |

## Verification
The bench builds the decoder with the package defaults: 6-bit opcode and function fields and a 4-bit operation code. With those widths the whole input space is only 4096 pairs. The bench sweeps every pair, so every illegal opcode, every unused function code under opcode zero, and every function value under each legal non-zero opcode is compared. Seeded random pairs and directed cases at the edges of the encoding are added on top of the sweep.

// File: rtl/ctrl_dec_pkg.sv
`timescale 1ns/1ps
package ctrl_dec_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int AOP_W = 4;

  typedef enum logic [AOP_W-1:0] {
    AOP_AND  = 4'h0,
    AOP_OR   = 4'h1,
    AOP_ADD  = 4'h2,
    AOP_ADDU = 4'h3,
    AOP_XOR  = 4'h4,
    AOP_SUBU = 4'h5,
    AOP_SUB  = 4'h6,
    AOP_SLT  = 4'h7,
    AOP_SLTU = 4'h8,
    AOP_NOR  = 4'hC
  } aop_e;

  typedef enum logic [2:0] {
    CLS_REG, CLS_IMM, CLS_LOAD, CLS_STORE, CLS_BEQ, CLS_JUMP, CLS_BAD
  } cls_e;

  localparam logic [OPC_W-1:0] OP_REG   = 6'b000000;
  localparam logic [OPC_W-1:0] OP_JMP   = 6'b000010;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OP_ADDI  = 6'b001000;
  localparam logic [OPC_W-1:0] OP_ADDIU = 6'b001001;
  localparam logic [OPC_W-1:0] OP_SLTI  = 6'b001010;
  localparam logic [OPC_W-1:0] OP_SLTIU = 6'b001011;
  localparam logic [OPC_W-1:0] OP_ANDI  = 6'b001100;
  localparam logic [OPC_W-1:0] OP_ORI   = 6'b001101;
  localparam logic [OPC_W-1:0] OP_XORI  = 6'b001110;
  localparam logic [OPC_W-1:0] OP_LDW   = 6'b100011;
  localparam logic [OPC_W-1:0] OP_STW   = 6'b101011;

  localparam logic [FN_W-1:0] FN_ADD  = 6'd32;
  localparam logic [FN_W-1:0] FN_ADDU = 6'd33;
  localparam logic [FN_W-1:0] FN_SUB  = 6'd34;
  localparam logic [FN_W-1:0] FN_SUBU = 6'd35;
  localparam logic [FN_W-1:0] FN_AND  = 6'd36;
  localparam logic [FN_W-1:0] FN_OR   = 6'd37;
  localparam logic [FN_W-1:0] FN_XOR  = 6'd38;
  localparam logic [FN_W-1:0] FN_NOR  = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT  = 6'd42;
  localparam logic [FN_W-1:0] FN_SLTU = 6'd43;

  typedef struct packed {
    logic reg_wr;
    logic dst_rd;
    logic src_imm;
    logic mem_to_reg;
    logic mem_rd;
    logic mem_wr;
    logic branch;
    logic jump;
    logic ext_sign;
  } ctl_t;

  localparam ctl_t CTL_NONE = '0;
endpackage

// File: rtl/ctrl_opc_class.sv
`timescale 1ns/1ps
// Classifies the major opcode and resolves the per-opcode immediate details.
module ctrl_opc_class
  import ctrl_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output cls_e             cls,
  output aop_e             imm_aop,
  output logic             imm_sext
);
  always_comb begin
    cls      = CLS_BAD;
    imm_aop  = AOP_AND;
    imm_sext = 1'b0;
    unique case (opcode)
      OP_REG:   cls = CLS_REG;
      OP_JMP:   cls = CLS_JUMP;
      OP_BEQ:   cls = CLS_BEQ;
      OP_LDW:   cls = CLS_LOAD;
      OP_STW:   cls = CLS_STORE;
      OP_ADDI:  begin cls = CLS_IMM; imm_aop = AOP_ADD;  imm_sext = 1'b1; end
      OP_ADDIU: begin cls = CLS_IMM; imm_aop = AOP_ADDU; imm_sext = 1'b1; end
      OP_SLTI:  begin cls = CLS_IMM; imm_aop = AOP_SLT;  imm_sext = 1'b1; end
      OP_SLTIU: begin cls = CLS_IMM; imm_aop = AOP_SLTU; imm_sext = 1'b1; end
      OP_ANDI:  begin cls = CLS_IMM; imm_aop = AOP_AND;  imm_sext = 1'b0; end
      OP_ORI:   begin cls = CLS_IMM; imm_aop = AOP_OR;   imm_sext = 1'b0; end
      OP_XORI:  begin cls = CLS_IMM; imm_aop = AOP_XOR;  imm_sext = 1'b0; end
      default:  cls = CLS_BAD;
    endcase
  end
endmodule

// File: rtl/ctrl_fn_decode.sv
`timescale 1ns/1ps
// Maps the function field of register-register instructions to an ALU code.
module ctrl_fn_decode
  import ctrl_dec_pkg::*;
(
  input  logic [FN_W-1:0] funct,
  output logic            fn_ok,
  output aop_e            fn_aop
);
  always_comb begin
    fn_ok  = 1'b1;
    fn_aop = AOP_AND;
    unique case (funct)
      FN_ADD:  fn_aop = AOP_ADD;
      FN_ADDU: fn_aop = AOP_ADDU;
      FN_SUB:  fn_aop = AOP_SUB;
      FN_SUBU: fn_aop = AOP_SUBU;
      FN_AND:  fn_aop = AOP_AND;
      FN_OR:   fn_aop = AOP_OR;
      FN_XOR:  fn_aop = AOP_XOR;
      FN_NOR:  fn_aop = AOP_NOR;
      FN_SLT:  fn_aop = AOP_SLT;
      FN_SLTU: fn_aop = AOP_SLTU;
      default: fn_ok  = 1'b0;
    endcase
  end
endmodule

// File: rtl/ctrl_line_gen.sv
`timescale 1ns/1ps
// Builds the control lines for each instruction class and squashes illegal ones.
module ctrl_line_gen
  import ctrl_dec_pkg::*;
(
  input  cls_e             cls,
  input  logic             fn_ok,
  input  aop_e             fn_aop,
  input  aop_e             imm_aop,
  input  logic             imm_sext,
  output ctl_t             ctl,
  output logic [AOP_W-1:0] aop,
  output logic             bad
);
  ctl_t ctl_raw;
  aop_e aop_raw;
  logic bad_raw;

  always_comb begin
    ctl_raw = CTL_NONE;
    aop_raw = AOP_AND;
    bad_raw = 1'b0;
    unique case (cls)
      CLS_REG: begin
        ctl_raw.reg_wr = 1'b1;
        ctl_raw.dst_rd = 1'b1;
        aop_raw        = fn_aop;
        bad_raw        = ~fn_ok;
      end
      CLS_IMM: begin
        ctl_raw.reg_wr   = 1'b1;
        ctl_raw.src_imm  = 1'b1;
        ctl_raw.ext_sign = imm_sext;
        aop_raw          = imm_aop;
      end
      CLS_LOAD: begin
        ctl_raw.reg_wr     = 1'b1;
        ctl_raw.src_imm    = 1'b1;
        ctl_raw.mem_to_reg = 1'b1;
        ctl_raw.mem_rd     = 1'b1;
        ctl_raw.ext_sign   = 1'b1;
        aop_raw            = AOP_ADD;
      end
      CLS_STORE: begin
        ctl_raw.src_imm  = 1'b1;
        ctl_raw.mem_wr   = 1'b1;
        ctl_raw.ext_sign = 1'b1;
        aop_raw          = AOP_ADD;
      end
      CLS_BEQ: begin
        ctl_raw.branch   = 1'b1;
        ctl_raw.ext_sign = 1'b1;
        aop_raw          = AOP_SUB;
      end
      CLS_JUMP: ctl_raw.jump = 1'b1;
      default:  bad_raw = 1'b1;
    endcase
  end

  // An illegal encoding must leave no trace on the datapath.
  always_comb begin
    bad = bad_raw;
    if (bad_raw) begin
      ctl = CTL_NONE;
      aop = '0;
    end else begin
      ctl = ctl_raw;
      aop = aop_raw;
    end
  end
endmodule

// File: rtl/instr_ctrl_decoder.sv
`timescale 1ns/1ps
module instr_ctrl_decoder
  import ctrl_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output logic             reg_wr,
  output logic             dst_rd,
  output logic             alu_src_imm,
  output logic             mem_to_reg,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             branch,
  output logic             jump,
  output logic             ext_sign,
  output logic [AOP_W-1:0] alu_op,
  output logic             illegal
);
  cls_e cls;
  aop_e imm_aop;
  aop_e fn_aop;
  logic imm_sext;
  logic fn_ok;
  ctl_t ctl;

  ctrl_opc_class u_cls (
    .opcode   (opcode),
    .cls      (cls),
    .imm_aop  (imm_aop),
    .imm_sext (imm_sext)
  );

  ctrl_fn_decode u_fn (
    .funct  (funct),
    .fn_ok  (fn_ok),
    .fn_aop (fn_aop)
  );

  ctrl_line_gen u_gen (
    .cls      (cls),
    .fn_ok    (fn_ok),
    .fn_aop   (fn_aop),
    .imm_aop  (imm_aop),
    .imm_sext (imm_sext),
    .ctl      (ctl),
    .aop      (alu_op),
    .bad      (illegal)
  );

  assign reg_wr      = ctl.reg_wr;
  assign dst_rd      = ctl.dst_rd;
  assign alu_src_imm = ctl.src_imm;
  assign mem_to_reg  = ctl.mem_to_reg;
  assign mem_rd      = ctl.mem_rd;
  assign mem_wr      = ctl.mem_wr;
  assign branch      = ctl.branch;
  assign jump        = ctl.jump;
  assign ext_sign    = ctl.ext_sign;
endmodule

// File: rtl/instr_ctrl_decoder_chk.sv
`timescale 1ns/1ps
module instr_ctrl_decoder_chk
  import ctrl_dec_pkg::*;
(
  input logic [OPC_W-1:0] opcode,
  input logic             reg_wr,
  input logic             dst_rd,
  input logic             alu_src_imm,
  input logic             mem_to_reg,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             branch,
  input logic             jump,
  input logic             ext_sign,
  input logic [AOP_W-1:0] alu_op,
  input logic             illegal
);
  always_comb begin
    assert_one_effect_R10: assert ($onehot0({branch, jump, mem_rd, mem_wr}));
    assert_wb_needs_read_R10: assert (!mem_to_reg || mem_rd);
    assert_illegal_quiet_R8: assert (!illegal || ({reg_wr, dst_rd, alu_src_imm, mem_to_reg,
        mem_rd, mem_wr, branch, jump, ext_sign, alu_op} == '0));
    assert_reg_dest_R1: assert (!(opcode == OP_REG && !illegal) || (reg_wr && dst_rd && !alu_src_imm));
    assert_store_no_write_R5: assert (!mem_wr || (!reg_wr && alu_src_imm && alu_op == AOP_ADD));
    assert_load_path_R4: assert (!mem_rd || (reg_wr && !dst_rd && mem_to_reg && alu_op == AOP_ADD));
    assert_beq_sub_R6: assert (!branch || (alu_op == AOP_SUB && !alu_src_imm && !reg_wr));
    assert_jump_bare_R7: assert (!jump || (!reg_wr && alu_op == '0 && !ext_sign));
    assert_imm_dest_R2: assert (!(alu_src_imm && reg_wr) || !dst_rd);
  end
endmodule

bind instr_ctrl_decoder instr_ctrl_decoder_chk u_chk (
  .opcode      (opcode),
  .reg_wr      (reg_wr),
  .dst_rd      (dst_rd),
  .alu_src_imm (alu_src_imm),
  .mem_to_reg  (mem_to_reg),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .branch      (branch),
  .jump        (jump),
  .ext_sign    (ext_sign),
  .alu_op      (alu_op),
  .illegal     (illegal)
);

// File: tb/instr_ctrl_decoder_test.sv
`timescale 1ns/1ps
module instr_ctrl_decoder_test;
  logic clk;
  logic rst_n;
  logic [5:0] opcode;
  logic [5:0] funct;
  logic reg_wr, dst_rd, alu_src_imm, mem_to_reg, mem_rd, mem_wr;
  logic branch, jump, ext_sign, illegal;
  logic [3:0] alu_op;
  int n_chk;
  int n_bad;
  bit done;

  instr_ctrl_decoder uut (
    .opcode(opcode), .funct(funct), .reg_wr(reg_wr), .dst_rd(dst_rd),
    .alu_src_imm(alu_src_imm), .mem_to_reg(mem_to_reg), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .branch(branch), .jump(jump), .ext_sign(ext_sign),
    .alu_op(alu_op), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {illegal, reg_wr, dst_rd, imm, m2r, mrd, mwr, br, jmp, sext, aop[3:0]}
  function automatic logic [13:0] model(input int op, input int fn);
    logic [3:0] a;
    case (op)
      0: begin
        case (fn)
          32: a = 4'b0010; 33: a = 4'b0011; 34: a = 4'b0110; 35: a = 4'b0101;
          36: a = 4'b0000; 37: a = 4'b0001; 38: a = 4'b0100; 39: a = 4'b1100;
          42: a = 4'b0111; 43: a = 4'b1000;
          default: return 14'b10_0000_0000_0000;
        endcase
        return {10'b0110000000, a};
      end
      8:  return {10'b0101000001, 4'b0010};
      9:  return {10'b0101000001, 4'b0011};
      10: return {10'b0101000001, 4'b0111};
      11: return {10'b0101000001, 4'b1000};
      12: return {10'b0101000000, 4'b0000};
      13: return {10'b0101000000, 4'b0001};
      14: return {10'b0101000000, 4'b0100};
      35: return {10'b0101110001, 4'b0010};
      43: return {10'b0001001001, 4'b0010};
      4:  return {10'b0000000101, 4'b0110};
      2:  return {10'b0000000010, 4'b0000};
      default: return 14'b10_0000_0000_0000;
    endcase
  endfunction

  function automatic string tag(input int op, input int fn);
    logic [13:0] e;
    e = model(op, fn);
    if (e[13]) return "R8";
    case (op)
      0: return "R1";
      35: return "R4";
      43: return "R5";
      4: return "R6";
      2: return "R7";
      default: return (op >= 12) ? "R3" : "R2";
    endcase
  endfunction

  task automatic apply(input int op, input int fn, input string req);
    logic [13:0] got;
    logic [13:0] exp;
    @(negedge clk);
    opcode = op[5:0];
    funct  = fn[5:0];
    #1;
    exp = model(op, fn);
    got = {illegal, reg_wr, dst_rd, alu_src_imm, mem_to_reg, mem_rd, mem_wr,
           branch, jump, ext_sign, alu_op};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d fn=%0d actual=%b expected=%b", req, op, fn, got, exp);
    end
    // R10: at most one effect, writeback from memory only with a read
    n_chk++;
    if ($countones({branch, jump, mem_rd, mem_wr}) > 1 || (mem_to_reg && !mem_rd)) begin
      n_bad++;
      $display("FAIL R10 op=%0d fn=%0d actual=%b expected=exclusive effects", op, fn, got);
    end
  endtask

  initial begin
    done = 1'b0;
    n_chk = 0;
    n_bad = 0;
    opcode = '0;
    funct = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Initial state: all-zero word is an unsupported function (R8)
    apply(0, 0, "R8");
    // Directed corners
    apply(0, 32, "R1");  apply(0, 39, "R1");  apply(0, 43, "R1");
    apply(0, 40, "R8");  apply(0, 44, "R8");  apply(0, 31, "R8");
    apply(8, 63, "R2");  apply(14, 0, "R3");  apply(11, 5, "R3");
    apply(35, 32, "R4"); apply(43, 0, "R5");  apply(4, 34, "R6");
    apply(2, 63, "R7");  apply(3, 32, "R8");  apply(63, 32, "R8");
    apply(15, 36, "R8"); apply(34, 0, "R8");
    // Exhaustive sweep; under non-zero opcodes funct has no effect (R9)
    for (int op = 0; op < 64; op++)
      for (int fn = 0; fn < 64; fn++)
        apply(op, fn, (op != 0) ? "R9" : tag(op, fn));
    // Seeded random pairs
    void'($urandom(32'd20240611));
    for (int k = 0; k < 1500; k++) begin
      int op;
      int fn;
      op = int'($urandom % 64);
      fn = int'($urandom % 64);
      apply(op, fn, tag(op, fn));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule